// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Direction Control

This block is one byte-wide general-purpose I/O port. It holds two registers behind a small register bus. The direction register decides, pin by pin, whether the pad is driven. The output latch holds the value that driven pads present. The upper six pins can each be switched to an output. The two lowest pins are built as inputs only and can never drive. Every pad input passes through a two-flop synchronizer before it reaches the read path. A read of the port register returns the latch bit for each output pin and the synchronized pad bit for each input pin.

The register bus has no handshake. A write takes effect at the next rising clock edge. A read is combinational from registered state, so read data is valid in the same cycle that the select is presented, and the bus never applies back-pressure.

An emulation-mode input hands direction-register traffic to an external bus. While it is high, a direction read returns the external read-data input in place of the register. A direction write still updates the register, and it also raises an external write strobe for that cycle, with the written byte on the external write-data output. Port-register traffic is not affected by emulation mode.

Top module: `pio_port8`

## Requirements
- R1: Reset (rst_n low) clears the direction register, the output latch and both synchronizer stages. After reset, pad_oe and pad_out are 0 and a direction read returns 0.
- R2: A write with bus_sel = 1 (direction register) sets pad_oe bits 7..2 to the written bits from the next clock edge on. A bit value of 1 makes the pin an output and 0 makes it a high-impedance input. A direction read outside emulation mode returns the stored value.
- R3: Direction bits 1 and 0 ignore writes and always read as 0. As a result, pad_oe[1:0] is 0 at all times.
- R4: A write with bus_sel = 0 (port register) loads the output latch from the next clock edge, whatever the direction setting. pad_out always shows the latch, so a value written while a pin is an input appears on the pad as soon as that pin becomes an output.
- R5: For a port read (bus_sel = 0), each bit whose direction is 1 returns the output-latch bit.
- R6: For a port read, each bit whose direction is 0 returns the pad value sampled two rising edges earlier, as seen through the two synchronizer stages.
- R7: Pins 1 and 0 always return their synchronized pad value on a port read, whatever was written to the direction register.
- R8: After a direction write, a port read reflects the new direction within 2 clock cycles. In this design the change is already visible in the cycle after the write edge.
- R9: While emu_mode = 1, a direction read returns ext_rdata. Port reads are unchanged by emu_mode.
- R10: While emu_mode = 1, a direction write asserts ext_wr_stb in the same cycle, with ext_wdata equal to bus_wdata, and still updates the direction register. ext_wr_stb stays 0 for every port write and for every write made outside emulation mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu_mode | input | 1 | Redirects direction-register traffic to the external bus |
| bus_sel | input | 1 | Register select: 0 = port register, 1 = direction register |
| bus_we | input | 1 | Write enable for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| ext_rdata | input | 8 | External-bus read data, returned on direction reads in emulation mode |
| ext_wr_stb | output | 1 | External-bus write strobe for direction writes in emulation mode |
| ext_wdata | output | 8 | External-bus write data |
| pad_in | input | 8 | Raw pad inputs (asynchronous) |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output data |

## Verification
The assertions check the following on every cycle:
- A direction write reaches pad_oe at the next edge, with the two low bits cleared.
- A port write reaches pad_out at the next edge.
- Output pins read back the latch.
- Input pins read back the pad value from two edges earlier.
- Emulation reads and strobes follow the external bus.

Only the bench scenarios can show the remaining behaviour. These are the reset values, a latch value that was staged while its pin was an input, the moment a pad change first becomes visible after a direction change, and a reset applied in the middle of operation.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // register select on the port's bus
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_DIR  = 1'b1
  } pio_sel_e;

  // mask of pins that may become outputs
  function automatic logic [31:0] drive_mask(input int width, input int locked);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i >= locked && i < width) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pio_dir_reg.sv
module pio_dir_reg #(
  parameter int WIDTH  = 8,
  parameter int LOCKED = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q
);
  localparam logic [WIDTH-1:0] MASK = WIDTH'(pio_pkg::drive_mask(WIDTH, LOCKED));

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < LOCKED) begin : g_fixed
      logic unused_wbit;
      assign unused_wbit = wdata[i];
      assign dir_q[i]    = 1'b0;
    end else begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (wr_en) q <= wdata[i];
      end
      assign dir_q[i] = q;
    end
  end

  // R2 / R3: a write lands masked at the next edge
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dir_q == ($past(wdata) & MASK));
  // R2: without a write the register holds
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dir_q));
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux #(
  parameter int WIDTH = 8
) (
  input  logic             sel_dir,
  input  logic             emu,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] sync_q,
  input  logic [WIDTH-1:0] ext_rdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] port_view;
  logic [WIDTH-1:0] dir_view;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      port_view[i] = dir_q[i] ? latch_q[i] : sync_q[i];
    end
    dir_view = emu ? ext_rdata : dir_q;
    rdata    = sel_dir ? dir_view : port_view;
  end
endmodule

// File: rtl/pio_port8.sv
module pio_port8 #(
  parameter int WIDTH       = 8,
  parameter int LOCKED_PINS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emu_mode,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] ext_rdata,
  output logic             ext_wr_stb,
  output logic [WIDTH-1:0] ext_wdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);
  import pio_pkg::*;

  logic             sel_dir;
  logic             dir_wr;
  logic             lat_wr;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] sync_q;

  assign sel_dir = (bus_sel == SEL_DIR);
  assign dir_wr  = bus_we && sel_dir;
  assign lat_wr  = bus_we && !sel_dir;

  pio_dir_reg #(.WIDTH(WIDTH), .LOCKED(LOCKED_PINS)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_en(dir_wr), .wdata(bus_wdata), .dir_q(dir_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      latch_q <= '0;
    else if (lat_wr) latch_q <= bus_wdata;
  end

  pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
  );

  pio_read_mux #(.WIDTH(WIDTH)) u_rd (
    .sel_dir(sel_dir), .emu(emu_mode), .dir_q(dir_q), .latch_q(latch_q),
    .sync_q(sync_q), .ext_rdata(ext_rdata), .rdata(bus_rdata)
  );

  assign pad_oe     = dir_q;
  assign pad_out    = latch_q;
  assign ext_wr_stb = emu_mode && dir_wr;
  assign ext_wdata  = bus_wdata;

  // cycles since reset, for checks that look back
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)         warm <= '0;
    else if (warm != 3) warm <= warm + 2'd1;
  end

  // R4: port writes reach the pad data at the next edge
  a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_sel) |=> pad_out == $past(bus_wdata));
  // R3: the lowest pins never drive
  a_r3_low_never_drive: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[LOCKED_PINS-1:0] == '0);
  // R5: output pins read back what they drive
  a_r5_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> ((bus_rdata & pad_oe) == (pad_out & pad_oe)));
  // R9: emulation direction reads come from the external bus
  a_r9_emu_read: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_mode && bus_sel) |-> bus_rdata == ext_rdata);
  // R10: the strobe only marks emulation-mode direction writes
  a_r10_stb_scope: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_stb |-> (emu_mode && bus_we && bus_sel && ext_wdata == bus_wdata));
  a_r10_stb_dir_update: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_stb |=> pad_oe[WIDTH-1:LOCKED_PINS] == $past(bus_wdata[WIDTH-1:LOCKED_PINS]));

  if (SYNC_STAGES == 2) begin : g_lat_chk
    // R6: input pins show the pad two edges late
    a_r6_input_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2 && !bus_sel) |-> ((bus_rdata & ~pad_oe) == ($past(pad_in, 2) & ~pad_oe)));
  end
endmodule

// File: tb/tb_pio_port8.sv
module tb_pio_port8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       emu_mode = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] ext_rdata = '0;
  logic       ext_wr_stb;
  logic [7:0] ext_wdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe;
  logic [7:0] pad_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;  // 250 MHz

  pio_port8 dut (
    .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_rdata(ext_rdata), .ext_wr_stb(ext_wr_stb), .ext_wdata(ext_wdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // vector: we, sel, emu, chk, wdata, pad, ext, expected rdata
  localparam int NV = 18;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,8'h00,8'h00}, // R1 dir reads 0
    {1'b0,1'b0,1'b0,1'b1,8'h00,8'h00,8'h00,8'h00}, // R1 port reads 0
    {1'b1,1'b1,1'b0,1'b0,8'hFF,8'h3C,8'h00,8'h00}, // dir <= FF
    {1'b0,1'b1,1'b0,1'b1,8'h00,8'h3C,8'h00,8'hFC}, // R3 low bits drop
    {1'b1,1'b0,1'b0,1'b0,8'h5A,8'h3C,8'h00,8'h00}, // latch <= 5A
    {1'b0,1'b0,1'b0,1'b1,8'h00,8'h3C,8'h00,8'h58}, // R5 latch on 7..2
    {1'b1,1'b1,1'b0,1'b0,8'h0F,8'h3C,8'h00,8'h00}, // dir <= 0C
    {1'b0,1'b0,1'b0,1'b1,8'h00,8'h3C,8'h00,8'h38}, // R8 new dir at once
    {1'b0,1'b0,1'b0,1'b1,8'h00,8'hC3,8'h00,8'h38}, // R6 pad not yet seen
    {1'b0,1'b0,1'b0,1'b1,8'h00,8'hC3,8'h00,8'h38}, // R6 one edge in
    {1'b0,1'b0,1'b0,1'b1,8'h00,8'hC3,8'h00,8'hCB}, // R7 two edges in
    {1'b1,1'b1,1'b0,1'b0,8'h00,8'hC3,8'h00,8'h00}, // dir <= 00
    {1'b0,1'b0,1'b0,1'b1,8'h00,8'hC3,8'h00,8'hC3}, // R6 all inputs
    {1'b0,1'b1,1'b1,1'b1,8'h00,8'hC3,8'h96,8'h96}, // R9 emu dir read
    {1'b0,1'b0,1'b1,1'b1,8'h00,8'hC3,8'h96,8'hC3}, // R9 emu port read
    {1'b1,1'b1,1'b1,1'b0,8'hF3,8'hC3,8'h96,8'h00}, // emu dir write
    {1'b0,1'b1,1'b0,1'b1,8'h00,8'hC3,8'h00,8'hF0}, // R10 reg updated
    {1'b1,1'b1,1'b0,1'b0,8'h00,8'hC3,8'h00,8'h00}  // dir <= 00
  };
  localparam string VTAG [NV] = '{
    "R1","R1","-","R3","-","R5","-","R8","R6","R6","R7","-","R6","R9","R9","-","R10","-"
  };

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; emu_mode = 1'b0; pad_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic sel, input logic emu, input logic [7:0] d,
                           input logic exp_stb, input string tag);
    @(negedge clk);
    bus_sel = sel; emu_mode = emu; bus_we = 1'b1; bus_wdata = d;
    #1;
    check(tag, {7'd0, ext_wr_stb}, {7'd0, exp_stb});
    if (exp_stb) check(tag, ext_wdata, d);
    @(negedge clk);
    bus_we = 1'b0; emu_mode = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      bus_we = VEC[v][35]; bus_sel = VEC[v][34]; emu_mode = VEC[v][33];
      bus_wdata = VEC[v][31:24]; pad_in = VEC[v][23:16]; ext_rdata = VEC[v][15:8];
      #1;
      if (VEC[v][32]) check(VTAG[v], bus_rdata, VEC[v][7:0]);
    end
    @(negedge clk);
    bus_we = 1'b0; emu_mode = 1'b0;

    // R1: reset state of the pad controls
    do_reset();
    #1;
    check("R1", pad_oe, 8'h00);
    check("R1", pad_out, 8'h00);

    // R4: latch staged while every pin is an input
    bus_write(1'b0, 1'b0, 8'hF0, 1'b0, "R4");
    #1;
    check("R4", pad_out, 8'hF0);
    check("R4", pad_oe, 8'h00);

    // R2 / R3: all pins asked to drive
    bus_write(1'b1, 1'b0, 8'hFF, 1'b0, "R2");
    #1;
    check("R2", pad_oe, 8'hFC);
    check("R3", pad_oe & 8'h03, 8'h00);
    check("R4", pad_out, 8'hF0);

    // R10: emulation strobe only for direction writes
    bus_write(1'b1, 1'b1, 8'h30, 1'b1, "R10");
    #1;
    check("R10", pad_oe, 8'h30);
    bus_write(1'b0, 1'b1, 8'h0F, 1'b0, "R10");
    bus_write(1'b1, 1'b0, 8'h44, 1'b0, "R10");
    #1;
    check("R2", pad_oe, 8'h44);

    // R1: reset in mid operation
    do_reset();
    bus_sel = 1'b1;
    #1;
    check("R1", bus_rdata, 8'h00);
    check("R1", pad_oe, 8'h00);
    check("R1", pad_out, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule